// File: doc/BRIEF.md
# Combinable Operate-Instruction Unit

This block executes the operate class of a 12-bit accumulator machine. It takes the nine operation bits of an operate word, the accumulator (AC), the one-bit link (L) and the front-panel switch register. It returns the new AC and L, together with a skip flag and a halt flag. Several operations can be encoded in the same word. They are applied in a fixed order, so a single word can, for example, clear, complement and then increment.

Operation bit 8 selects between two groups. The first group clears and complements AC and L, increments the 13-bit pair L:AC, and rotates L:AC left or right by one or two places. The second group evaluates a skip condition and can also clear AC, OR the switches into AC, and request a halt. Operation bit 3 chooses how the selected skip tests are combined: any of them (OR) or all of them (AND). The result is registered, and `done` marks the cycle in which it is valid.

Top module: `opr_unit`

## Requirements
- R1: One cycle after `issue` is high at a clock edge, `done` is 1 and the outputs carry that word's result. `done` is 0 in the cycle after an edge with `issue` low. Reset clears `done`, `acc_out`, `link_out`, `skip` and `halt`.
- R2: `op_bits[8]` selects the group: 0 for the first group, 1 for the second. The same low bits act differently in each group (for example, bit 1 is "rotate twice" in the first group and halt in the second).
- R3: First group, clears before complements. Bit 7 clears AC, bit 6 clears L, bit 5 inverts AC, bit 4 inverts L. Clear together with invert therefore gives all ones.
- R4: First group, bit 0 adds one to the 13-bit L:AC. This happens after the clears and complements, and a carry out of AC toggles L.
- R5: First group, rotation is applied last, through L:AC. Bit 3 rotates right and bit 2 rotates left. Bit 1 makes the rotation two places. With both directions set, or with bit 1 alone, no rotation happens.
- R6: A first-group word never raises `skip` or `halt`.
- R7: Second group with bit 3 = 0 (OR sense): bit 6 tests AC negative (AC bit 11 set), bit 5 tests AC zero, and bit 4 tests L = 1. The skip is taken if any selected test is true, and is not taken if none is selected.
- R8: Second group with bit 3 = 1 (AND sense): bit 6 tests AC bit 11 clear, bit 5 tests AC nonzero, and bit 4 tests L = 0. The skip is taken only if every selected test is true, so it is always taken when none is selected.
- R9: The skip tests see AC as it was before any second-group clear.
- R10: Second group: bit 7 clears AC, then bit 2 ORs `switches` into AC, so both together load the switches. L passes through unchanged, and bit 0 is ignored.
- R11: Second group: bit 1 raises `halt`.
- R12: A first-group word with bits 7..0 all zero leaves AC and L unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Execute the presented word at this edge |
| op_bits | input | 9 | Operation field of the operate word |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link bit |
| switches | input | 12 | Front-panel switch register |
| done | output | 1 | Result valid |
| acc_out | output | 12 | New accumulator |
| link_out | output | 1 | New link bit |
| skip | output | 1 | Skip the next instruction |
| halt | output | 1 | Halt request |

## Verification
Every result (AC, L, skip and halt) comes through exactly one register, so it is due on the first rising edge after the edge that samples `issue`. The bench drives each word on a falling edge and samples the outputs at the next falling edge. By then exactly one rising edge has passed, so each check reads the result of the word driven just before it. All 512 operation-field values are swept against a set of AC and L corner values. Directed cases then confirm the reset state, the drop of `done`, pre-clear skip evaluation and the group split.

// File: rtl/opr_pkg.sv
package opr_pkg;
    localparam int WORD_W = 12;
    localparam int OP_W   = 9;
    localparam int PAIR_W = WORD_W + 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PAIR_W-1:0] pair_t;

    typedef struct packed {
        logic zero_acc;
        logic zero_lnk;
        logic inv_acc;
        logic inv_lnk;
        logic rot_r;
        logic rot_l;
        logic dbl;
        logic inc;
    } g1_ctl_t;

    typedef struct packed {
        logic zero_acc;
        logic t_sign;
        logic t_zero;
        logic t_link;
        logic all_sense;
        logic or_sw;
        logic stop;
    } g2_ctl_t;

    typedef struct packed {
        word_t acc;
        logic  link;
        logic  skip;
        logic  halt;
    } opr_res_t;

    function automatic g1_ctl_t decode_g1(input logic [7:0] b);
        g1_ctl_t c;
        c.zero_acc = b[7];
        c.zero_lnk = b[6];
        c.inv_acc  = b[5];
        c.inv_lnk  = b[4];
        c.rot_r    = b[3];
        c.rot_l    = b[2];
        c.dbl      = b[1];
        c.inc      = b[0];
        return c;
    endfunction

    function automatic g2_ctl_t decode_g2(input logic [7:1] b);
        g2_ctl_t c;
        c.zero_acc  = b[7];
        c.t_sign    = b[6];
        c.t_zero    = b[5];
        c.t_link    = b[4];
        c.all_sense = b[3];
        c.or_sw     = b[2];
        c.stop      = b[1];
        return c;
    endfunction

    function automatic pair_t rotl1(input pair_t v);
        return {v[PAIR_W-2:0], v[PAIR_W-1]};
    endfunction

    function automatic pair_t rotr1(input pair_t v);
        return {v[0], v[PAIR_W-1:1]};
    endfunction
endpackage

// File: rtl/opr_grp1.sv
module opr_grp1
    import opr_pkg::*;
(
    input  g1_ctl_t ctl,
    input  word_t   acc_i,
    input  logic    link_i,
    output word_t   acc_o,
    output logic    link_o
);
    localparam int MAX_STEPS = 2;

    pair_t stage_clr;
    pair_t stage_inv;
    pair_t stage_inc;
    pair_t rot_chain_l [MAX_STEPS+1];
    pair_t rot_chain_r [MAX_STEPS+1];
    pair_t stage_rot;
    logic  do_rot;

    always_comb begin
        stage_clr = {ctl.zero_lnk ? 1'b0 : link_i,
                     ctl.zero_acc ? '0 : acc_i};
        stage_inv = stage_clr ^ {ctl.inv_lnk, {WORD_W{ctl.inv_acc}}};
        stage_inc = stage_inv + pair_t'(ctl.inc);
    end

    assign rot_chain_l[0] = stage_inc;
    assign rot_chain_r[0] = stage_inc;

    generate
        for (genvar s = 0; s < MAX_STEPS; s++) begin : g_rot
            assign rot_chain_l[s+1] = rotl1(rot_chain_l[s]);
            assign rot_chain_r[s+1] = rotr1(rot_chain_r[s]);
        end
    endgenerate

    assign do_rot = ctl.rot_l ^ ctl.rot_r;

    always_comb begin
        if (!do_rot)
            stage_rot = stage_inc;
        else if (ctl.rot_l)
            stage_rot = ctl.dbl ? rot_chain_l[2] : rot_chain_l[1];
        else
            stage_rot = ctl.dbl ? rot_chain_r[2] : rot_chain_r[1];
    end

    assign acc_o  = stage_rot[WORD_W-1:0];
    assign link_o = stage_rot[WORD_W];
endmodule

// File: rtl/opr_grp2.sv
module opr_grp2
    import opr_pkg::*;
(
    input  g2_ctl_t ctl,
    input  word_t   acc_i,
    input  logic    link_i,
    input  word_t   sw_i,
    output word_t   acc_o,
    output logic    skip_o,
    output logic    halt_o
);
    logic is_neg;
    logic is_zero;
    logic any_hit;
    logic all_hit;
    word_t cleared;

    always_comb begin
        is_neg  = acc_i[WORD_W-1];
        is_zero = (acc_i == '0);
        any_hit = (ctl.t_sign & is_neg) | (ctl.t_zero & is_zero) | (ctl.t_link & link_i);
        all_hit = (~ctl.t_sign | ~is_neg) & (~ctl.t_zero | ~is_zero) & (~ctl.t_link | ~link_i);
        skip_o  = ctl.all_sense ? all_hit : any_hit;
        cleared = ctl.zero_acc ? '0 : acc_i;
        acc_o   = cleared | (ctl.or_sw ? sw_i : '0);
        halt_o  = ctl.stop;
    end
endmodule

// File: rtl/opr_unit.sv
module opr_unit
    import opr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue,
    input  logic [8:0]  op_bits,
    input  logic [11:0] acc_in,
    input  logic        link_in,
    input  logic [11:0] switches,
    output logic        done,
    output logic [11:0] acc_out,
    output logic        link_out,
    output logic        skip,
    output logic        halt
);
    g1_ctl_t  c1;
    g2_ctl_t  c2;
    word_t    g1_acc;
    logic     g1_link;
    word_t    g2_acc;
    logic     g2_skip;
    logic     g2_halt;
    opr_res_t res_d;
    opr_res_t res_q;
    logic     done_q;
    logic     grp2_q;

    assign c1 = decode_g1(op_bits[7:0]);
    assign c2 = decode_g2(op_bits[7:1]);

    opr_grp1 u_grp1 (
        .ctl    (c1),
        .acc_i  (acc_in),
        .link_i (link_in),
        .acc_o  (g1_acc),
        .link_o (g1_link)
    );

    opr_grp2 u_grp2 (
        .ctl    (c2),
        .acc_i  (acc_in),
        .link_i (link_in),
        .sw_i   (switches),
        .acc_o  (g2_acc),
        .skip_o (g2_skip),
        .halt_o (g2_halt)
    );

    always_comb begin
        if (op_bits[8])
            res_d = '{acc: g2_acc, link: link_in, skip: g2_skip, halt: g2_halt};
        else
            res_d = '{acc: g1_acc, link: g1_link, skip: 1'b0, halt: 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
            grp2_q <= 1'b0;
        end else begin
            done_q <= issue;
            if (issue) begin
                res_q  <= res_d;
                grp2_q <= op_bits[8];
            end
        end
    end

    assign done     = done_q;
    assign acc_out  = res_q.acc;
    assign link_out = res_q.link;
    assign skip     = res_q.skip;
    assign halt     = res_q.halt;

    AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        issue |=> done); // R1
    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (rst)
        !issue |=> !done); // R1
    AST_G1_QUIET: assert property (@(posedge clk) disable iff (rst)
        (done && !grp2_q) |-> (!skip && !halt)); // R6
    AST_G2_LINK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (issue && op_bits[8]) |=> (link_out == $past(link_in))); // R10
    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (issue && op_bits == 9'd0) |=> (acc_out == $past(acc_in) && link_out == $past(link_in))); // R12
    AST_HALT_REQ: assert property (@(posedge clk) disable iff (rst)
        (issue && op_bits[8] && op_bits[1]) |=> halt); // R11
    AST_LOAD_SWITCHES: assert property (@(posedge clk) disable iff (rst)
        (issue && op_bits[8] && op_bits[7] && op_bits[2]) |=> (acc_out == $past(switches))); // R10
    AST_AND_EMPTY_SKIPS: assert property (@(posedge clk) disable iff (rst)
        (issue && op_bits[8] && op_bits[3] && op_bits[6:4] == 3'b000) |=> skip); // R8
endmodule

// File: tb/opr_unit_tb.sv
module opr_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [8:0]  op_bits = '0;
    logic [11:0] acc_in = '0;
    logic        link_in = 1'b0;
    logic [11:0] switches = '0;
    logic        done;
    logic [11:0] acc_out;
    logic        link_out;
    logic        skip;
    logic        halt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    opr_unit u_dut (
        .clk(clk), .rst(rst), .issue(issue), .op_bits(op_bits),
        .acc_in(acc_in), .link_in(link_in), .switches(switches),
        .done(done), .acc_out(acc_out), .link_out(link_out),
        .skip(skip), .halt(halt)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // expected {halt, skip, link, acc}
    function automatic logic [14:0] model(input logic [8:0] op, input int a, input int l, input int sw);
        int v, n, r, res_acc, res_l, sk, hl;
        sk = 0; hl = 0;
        if (!op[8]) begin
            v = l * 4096 + a;
            if (op[7]) v = v & 4096;
            if (op[6]) v = v & 4095;
            if (op[5]) v = v ^ 4095;
            if (op[4]) v = v ^ 4096;
            if (op[0]) v = (v + 1) % 8192;
            n = op[1] ? 2 : 1;
            if (op[2] && !op[3]) v = ((v << n) | (v >> (13 - n))) & 8191;
            if (op[3] && !op[2]) v = ((v >> n) | (v << (13 - n))) & 8191;
            res_acc = v % 4096;
            res_l = v / 4096;
        end else begin
            if (!op[3])
                sk = int'((op[6] && a >= 2048) || (op[5] && a == 0) || (op[4] && l == 1));
            else
                sk = int'((!op[6] || a < 2048) && (!op[5] || a != 0) && (!op[4] || l == 0));
            r = op[7] ? 0 : a;
            if (op[2]) r = r | sw;
            res_acc = r;
            res_l = l;
            hl = int'(op[1]);
        end
        return {1'(hl), 1'(sk), 1'(res_l), 12'(res_acc)};
    endfunction

    task automatic drive(input logic [8:0] op, input logic [11:0] a, input logic l, input logic [11:0] sw);
        @(negedge clk);
        issue = 1'b1; op_bits = op; acc_in = a; link_in = l; switches = sw;
        @(negedge clk);
    endtask

    task automatic check_op(input logic [8:0] op, input logic [11:0] a, input logic l, input logic [11:0] sw);
        logic [14:0] e;
        string tag;
        e = model(op, int'(a), int'(l), int'(sw));
        drive(op, a, l, sw);
        chk("R1 done", int'(done), 1);
        if (!op[8]) begin
            if (op[3] || op[2]) tag = "R5 rotate";
            else if (op[0]) tag = "R4 increment";
            else if (op == 9'd0) tag = "R12 nop";
            else tag = "R3 clear/complement";
            chk(tag, int'({link_out, acc_out}), int'(e[12:0]));
            chk("R6 no skip/halt", int'({halt, skip}), int'(e[14:13]));
        end else begin
            chk(op[3] ? "R8 and-sense skip" : "R7 or-sense skip", int'(skip), int'(e[13]));
            chk("R10 acc/link", int'({link_out, acc_out}), int'(e[12:0]));
            chk("R11 halt", int'(halt), int'(e[14]));
        end
    endtask

    initial begin
        logic [11:0] pats [8];
        pats = '{12'o0000, 12'o0001, 12'o7777, 12'o4000, 12'o3777, 12'o2525, 12'o5252, 12'o0777};
        repeat (3) @(negedge clk);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset outputs", int'({halt, skip, link_out, acc_out}), 0);
        rst = 1'b0;

        for (int p = 0; p < 8; p++) begin
            for (int l = 0; l < 2; l++) begin
                for (int op = 0; op < 512; op++) begin
                    check_op(9'(op), pats[p], 1'(l), pats[p] ^ 12'o6061);
                end
            end
        end

        // R9: skip sees AC before the clear
        drive(9'b1_1010_0000, 12'o0005, 1'b0, 12'o0000);
        chk("R9 pre-clear skip", int'({skip, acc_out}), int'({1'b0, 12'o0000}));
        drive(9'b1_1010_1000, 12'o0005, 1'b0, 12'o0000);
        chk("R9 pre-clear and-skip", int'({skip, acc_out}), int'({1'b1, 12'o0000}));

        // R2: bit 1 means double-rotate in group one, halt in group two
        drive(9'b0_0000_0010, 12'o1234, 1'b1, 12'o0000);
        chk("R2 group one bit1", int'({halt, link_out, acc_out}), int'({1'b0, 1'b1, 12'o1234}));
        drive(9'b1_0000_0010, 12'o1234, 1'b1, 12'o0000);
        chk("R2 group two bit1", int'(halt), 1);

        // R3: clear plus complement yields ones
        drive(9'b0_1111_0000, 12'o0123, 1'b0, 12'o0000);
        chk("R3 clear then complement", int'({link_out, acc_out}), int'(13'h1FFF));

        // R4: carry toggles link
        drive(9'b0_0000_0001, 12'o7777, 1'b0, 12'o0000);
        chk("R4 carry into link", int'({link_out, acc_out}), int'(13'h1000));

        // R10: clear + or-switches loads switches
        drive(9'b1_1000_0100, 12'o7070, 1'b1, 12'o1357);
        chk("R10 load switches", int'(acc_out), int'(12'o1357));

        @(negedge clk);
        issue = 1'b0;
        @(negedge clk);
        chk("R1 done drops", int'(done), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule